// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block takes a simple 32-bit RISC core into an exception handler. In every cycle it decides whether an exception starts. The candidates are a synchronous cause reported by the pipeline (a system call, for example) and the level-sensitive external and tick-timer interrupt requests. Each interrupt request is gated by its own enable bit in the live status register. When an exception is accepted, one clock edge does all of the entry work. The saved exception PC is formed from the current PC, with a correction when the faulting instruction sits in a branch delay slot and another for system calls. The status register is snapshotted into the exception status register. The live status register is then forced into supervisor mode, with both MMUs and both interrupt enables turned off.

In the cycle after acceptance, the block raises a one-cycle redirect pulse carrying the handler vector, which is the cause number shifted left by eight. A TLB-flush pulse and a cause report go out in the same cycle, and the cause report then returns to an idle value of zero. A cause code outside the defined range raises a fatal pulse instead and leaves all state untouched. A return strobe restores the status register from the exception status register and redirects fetch to the saved exception PC. A status write port lets the pipeline load the status register when nothing else is happening.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status register reads 0x0001 (supervisor bit only). The exception status register and exception PC read zero, cause_o reads 0, and no pulse output is high.
- R2: On entry the exception PC takes pc_i. If in_dslot_i is high, it takes pc_i minus 4 (modulo 2^32), status bit 13 (delay-slot exception) is set, and dslot_clr_o pulses together with the redirect.
- R3: For the system-call cause (code 12), 4 is added to the exception PC after any delay-slot correction.
- R4: On entry the exception status register takes the prior status register value, including bit 13 if R2 set it. The new status register clears bit 1 (tick enable), bit 2 (external enable), bit 5 (data MMU) and bit 6 (instruction MMU), and sets bit 0 (supervisor). All other bits keep their values.
- R5: An entry accepted at a clock edge makes redirect_o high for exactly the following cycle, with redirect_pc_o equal to the cause code shifted left by 8.
- R6: An external request (cause 8) is taken only while status bit 2 is set. A tick request (cause 5) is taken only while status bit 1 is set. A request that is not enabled causes no output activity and no state change.
- R7: When enabled external and tick requests are pending together, the tick cause (5) is taken.
- R8: A valid synchronous cause wins over any interrupt request in the same cycle.
- R9: A synchronous cause of 0, or one at or above NUM_CAUSES (14), raises fatal_o for one cycle. In that case there is no redirect, no flush, and no change to the status register, the exception status register or the exception PC.
- R10: tlb_flush_o pulses for one cycle on every entry and at no other time.
- R11: cause_o shows the taken cause during the redirect cycle of an entry and reads 0 in every other cycle.
- R12: When no entry or fatal event occurs, rfe_i copies the exception status register into the status register and pulses redirect_o with redirect_pc_o equal to the exception PC. There is no flush in that cycle.
- R13: When there is no entry, fatal event or return, sr_wr_i loads sr_wr_data_i into the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ext_i | input | 1 | External interrupt request level |
| irq_tick_i | input | 1 | Tick-timer interrupt request level |
| sync_valid_i | input | 1 | Synchronous cause present this cycle |
| sync_cause_i | input | CAUSE_W | Synchronous cause code |
| pc_i | input | XLEN | PC of the instruction being interrupted |
| in_dslot_i | input | 1 | That instruction is in a branch delay slot |
| rfe_i | input | 1 | Return-from-exception strobe |
| sr_wr_i | input | 1 | Status register write strobe |
| sr_wr_data_i | input | 16 | Status register write data |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | XLEN | Redirect target, valid with redirect_o |
| tlb_flush_o | output | 1 | One-cycle TLB flush request |
| fatal_o | output | 1 | One-cycle unhandled-cause pulse |
| cause_o | output | CAUSE_W | Cause taken, zero when idle |
| dslot_clr_o | output | 1 | Clears the pipeline delay-slot flag |
| sr_o | output | 16 | Live status register |
| esr_o | output | 16 | Exception status register |
| epcr_o | output | XLEN | Exception PC register |

## Verification
The bench uses the default parameters: XLEN of 32, a four-bit cause field, NUM_CAUSES of 14 and delay-slot correction enabled. With a four-bit field, the out-of-range codes 14 and 15 and the code 0 can all be driven, so every path into the fatal response is reachable next to the largest valid code, 13. A full-width PC lets a delay-slot entry at address zero wrap to 0xFFFFFFFC. With the eight-bit vector shift, every vector address stays inside the PC width.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int SR_W = 16;

   // status bit positions
   localparam int SR_SUPV    = 0;
   localparam int SR_TICK_EN = 1;
   localparam int SR_EXT_EN  = 2;
   localparam int SR_DMMU_EN = 5;
   localparam int SR_IMMU_EN = 6;
   localparam int SR_DSLOT_X = 13;

   localparam logic [SR_W-1:0] SR_RESET_VAL = 16'h0001;
   localparam logic [SR_W-1:0] SR_SUPV_BIT  = 16'h0001;
   localparam logic [SR_W-1:0] SR_DSX_BIT   = 16'h2000;
   localparam logic [SR_W-1:0] SR_OFF_MASK  = 16'h0066;

   // fixed cause codes
   localparam int CAUSE_TICK    = 5;
   localparam int CAUSE_EXT     = 8;
   localparam int CAUSE_SYSCALL = 12;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_SYNC = 3'd1,
      SRC_TICK = 3'd2,
      SRC_EXT  = 3'd3,
      SRC_BAD  = 3'd4
   } exc_src_e;

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
   import exc_entry_pkg::*;
#(
   parameter int CAUSE_W    = 4,
   parameter int NUM_CAUSES = 14
) (
   input  logic               sync_valid_i,
   input  logic [CAUSE_W-1:0] sync_cause_i,
   input  logic               irq_ext_i,
   input  logic               irq_tick_i,
   input  logic               ext_en_i,
   input  logic               tick_en_i,
   output exc_src_e           src_o,
   output logic [CAUSE_W-1:0] cause_o
);

   localparam logic [CAUSE_W:0] LIMIT = (CAUSE_W+1)'(NUM_CAUSES);

   // priority: pipeline cause, then tick, then external
   always_comb begin
      src_o   = SRC_NONE;
      cause_o = '0;
      if (sync_valid_i) begin
         cause_o = sync_cause_i;
         if (sync_cause_i == '0 || {1'b0, sync_cause_i} >= LIMIT)
            src_o = SRC_BAD;
         else
            src_o = SRC_SYNC;
      end else if (irq_tick_i && tick_en_i) begin
         src_o   = SRC_TICK;
         cause_o = CAUSE_W'(CAUSE_TICK);
      end else if (irq_ext_i && ext_en_i) begin
         src_o   = SRC_EXT;
         cause_o = CAUSE_W'(CAUSE_EXT);
      end
   end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CAUSE_W   = 4,
   parameter int VEC_SHIFT = 8,
   parameter bit DSLOT_EN  = 1'b1
) (
   input  logic [SR_W-1:0]    sr_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic               in_dslot_i,
   input  logic               is_syscall_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic [SR_W-1:0]    next_sr_o,
   output logic [SR_W-1:0]    next_esr_o,
   output logic [XLEN-1:0]    next_epcr_o,
   output logic [XLEN-1:0]    vector_o,
   output logic               dslot_taken_o
);

   localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

   logic            ds;
   logic [SR_W-1:0] sr_marked;

   generate
      if (DSLOT_EN) begin : g_dslot
         assign ds = in_dslot_i;
      end else begin : g_no_dslot
         assign ds = 1'b0;
      end
   endgenerate

   assign dslot_taken_o = ds;
   assign sr_marked     = ds ? (sr_i | SR_DSX_BIT) : sr_i;
   assign next_esr_o    = sr_marked;
   assign next_sr_o     = (sr_marked & ~SR_OFF_MASK) | SR_SUPV_BIT;
   assign next_epcr_o   = pc_i - (ds ? INSN_BYTES : '0)
                               + (is_syscall_i ? INSN_BYTES : '0);
   assign vector_o      = XLEN'(cause_i) << VEC_SHIFT;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int CAUSE_W    = 4,
   parameter int NUM_CAUSES = 14,
   parameter int VEC_SHIFT  = 8,
   parameter bit DSLOT_EN   = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               irq_ext_i,
   input  logic               irq_tick_i,
   input  logic               sync_valid_i,
   input  logic [CAUSE_W-1:0] sync_cause_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic               in_dslot_i,
   input  logic               rfe_i,
   input  logic               sr_wr_i,
   input  logic [15:0]        sr_wr_data_i,
   output logic               redirect_o,
   output logic [XLEN-1:0]    redirect_pc_o,
   output logic               tlb_flush_o,
   output logic               fatal_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               dslot_clr_o,
   output logic [15:0]        sr_o,
   output logic [15:0]        esr_o,
   output logic [XLEN-1:0]    epcr_o
);

   generate
      if (NUM_CAUSES > (1 << CAUSE_W) || NUM_CAUSES < 2) begin : g_bad_ncause
         $error("NUM_CAUSES must lie in 2 .. 2**CAUSE_W");
      end
      if (CAUSE_SYSCALL >= NUM_CAUSES || CAUSE_EXT >= NUM_CAUSES ||
          CAUSE_TICK >= NUM_CAUSES) begin : g_bad_codes
         $error("fixed cause codes must be below NUM_CAUSES");
      end
      if (VEC_SHIFT + CAUSE_W > XLEN) begin : g_bad_vec
         $error("vector address does not fit in XLEN");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN too small");
      end
   endgenerate

   exc_src_e           src;
   logic [CAUSE_W-1:0] sel_cause;
   logic [SR_W-1:0]    sr_q, esr_q, n_sr, n_esr;
   logic [XLEN-1:0]    epcr_q, n_epcr, vector, redir_pc_q;
   logic               ds_taken, is_sys;
   logic               redirect_q, flush_q, fatal_q, dsclr_q;
   logic [CAUSE_W-1:0] cause_q;

   exc_cause_sel #(
      .CAUSE_W   (CAUSE_W),
      .NUM_CAUSES(NUM_CAUSES)
   ) u_sel (
      .sync_valid_i(sync_valid_i),
      .sync_cause_i(sync_cause_i),
      .irq_ext_i   (irq_ext_i),
      .irq_tick_i  (irq_tick_i),
      .ext_en_i    (sr_q[SR_EXT_EN]),
      .tick_en_i   (sr_q[SR_TICK_EN]),
      .src_o       (src),
      .cause_o     (sel_cause)
   );

   assign is_sys = (src == SRC_SYNC) && (sel_cause == CAUSE_W'(CAUSE_SYSCALL));

   exc_state_calc #(
      .XLEN     (XLEN),
      .CAUSE_W  (CAUSE_W),
      .VEC_SHIFT(VEC_SHIFT),
      .DSLOT_EN (DSLOT_EN)
   ) u_calc (
      .sr_i         (sr_q),
      .pc_i         (pc_i),
      .in_dslot_i   (in_dslot_i),
      .is_syscall_i (is_sys),
      .cause_i      (sel_cause),
      .next_sr_o    (n_sr),
      .next_esr_o   (n_esr),
      .next_epcr_o  (n_epcr),
      .vector_o     (vector),
      .dslot_taken_o(ds_taken)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q       <= SR_RESET_VAL;
         esr_q      <= '0;
         epcr_q     <= '0;
         redir_pc_q <= '0;
         redirect_q <= 1'b0;
         flush_q    <= 1'b0;
         fatal_q    <= 1'b0;
         dsclr_q    <= 1'b0;
         cause_q    <= '0;
      end else begin
         redirect_q <= 1'b0;
         flush_q    <= 1'b0;
         fatal_q    <= 1'b0;
         dsclr_q    <= 1'b0;
         cause_q    <= '0;
         case (src)
            SRC_SYNC, SRC_TICK, SRC_EXT: begin
               sr_q       <= n_sr;
               esr_q      <= n_esr;
               epcr_q     <= n_epcr;
               redirect_q <= 1'b1;
               redir_pc_q <= vector;
               flush_q    <= 1'b1;
               cause_q    <= sel_cause;
               dsclr_q    <= ds_taken;
            end
            SRC_BAD: begin
               fatal_q <= 1'b1;
            end
            default: begin
               if (rfe_i) begin
                  sr_q       <= esr_q;
                  redirect_q <= 1'b1;
                  redir_pc_q <= epcr_q;
               end else if (sr_wr_i) begin
                  sr_q <= sr_wr_data_i;
               end
            end
         endcase
      end
   end

   assign redirect_o    = redirect_q;
   assign redirect_pc_o = redir_pc_q;
   assign tlb_flush_o   = flush_q;
   assign fatal_o       = fatal_q;
   assign cause_o       = cause_q;
   assign dslot_clr_o   = dsclr_q;
   assign sr_o          = sr_q;
   assign esr_o         = esr_q;
   assign epcr_o        = epcr_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CAUSE_W   = 4,
   parameter int VEC_SHIFT = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               irq_ext_i,
   input logic               irq_tick_i,
   input logic               sync_valid_i,
   input logic               redirect_o,
   input logic [XLEN-1:0]    redirect_pc_o,
   input logic               tlb_flush_o,
   input logic               fatal_o,
   input logic [CAUSE_W-1:0] cause_o,
   input logic [15:0]        sr_o,
   input logic [15:0]        esr_o,
   input logic [XLEN-1:0]    epcr_o
);

   p_flush_is_entry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tlb_flush_o |-> (redirect_o && cause_o != '0));

   p_supervisor_on_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tlb_flush_o |-> (sr_o[SR_SUPV] && !sr_o[SR_TICK_EN] && !sr_o[SR_EXT_EN]
                       && !sr_o[SR_DMMU_EN] && !sr_o[SR_IMMU_EN]));

   p_esr_snapshot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tlb_flush_o |-> ((esr_o & ~SR_DSX_BIT) == ($past(sr_o) & ~SR_DSX_BIT)));

   p_fatal_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fatal_o |-> (!redirect_o && !tlb_flush_o && $stable(sr_o)
                   && $stable(esr_o) && $stable(epcr_o)));

   p_tick_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_valid_i && irq_tick_i && irq_ext_i && sr_o[SR_TICK_EN] && sr_o[SR_EXT_EN])
      |=> (cause_o == CAUSE_W'(CAUSE_TICK)));

   p_gated_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_valid_i && !(irq_tick_i && sr_o[SR_TICK_EN]) && !(irq_ext_i && sr_o[SR_EXT_EN]))
      |=> !tlb_flush_o);

   p_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tlb_flush_o |-> (redirect_pc_o == (XLEN'(cause_o) << VEC_SHIFT)));

   p_cause_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !redirect_o |-> (cause_o == '0));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .XLEN     (XLEN),
   .CAUSE_W  (CAUSE_W),
   .VEC_SHIFT(VEC_SHIFT)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .irq_ext_i    (irq_ext_i),
   .irq_tick_i   (irq_tick_i),
   .sync_valid_i (sync_valid_i),
   .redirect_o   (redirect_o),
   .redirect_pc_o(redirect_pc_o),
   .tlb_flush_o  (tlb_flush_o),
   .fatal_o      (fatal_o),
   .cause_o      (cause_o),
   .sr_o         (sr_o),
   .esr_o        (esr_o),
   .epcr_o       (epcr_o)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

   localparam int XLEN = 32;
   localparam int CW   = 4;
   localparam int NC   = 14;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            irq_ext = 1'b0, irq_tick = 1'b0, sv = 1'b0, ds = 1'b0;
   logic            rfe = 1'b0, wr = 1'b0;
   logic [CW-1:0]   sc = '0;
   logic [XLEN-1:0] pc = '0;
   logic [15:0]     wd = '0;
   logic            redirect, flush, fatal, dclr;
   logic [XLEN-1:0] rpc, epcr;
   logic [CW-1:0]   cause;
   logic [15:0]     sr, esr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0]     m_sr = 16'h0001, m_esr = '0;
   logic [XLEN-1:0] m_epcr = '0;

   always #2.5 clk = ~clk;

   exc_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .NUM_CAUSES(NC)) i_exc_entry_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .irq_ext_i(irq_ext), .irq_tick_i(irq_tick),
      .sync_valid_i(sv), .sync_cause_i(sc), .pc_i(pc), .in_dslot_i(ds),
      .rfe_i(rfe), .sr_wr_i(wr), .sr_wr_data_i(wd),
      .redirect_o(redirect), .redirect_pc_o(rpc), .tlb_flush_o(flush),
      .fatal_o(fatal), .cause_o(cause), .dslot_clr_o(dclr),
      .sr_o(sr), .esr_o(esr), .epcr_o(epcr));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, predict, check after the edge
   task automatic step(input logic i_sv, input logic [CW-1:0] i_sc, input logic i_ext,
                       input logic i_tick, input logic i_ds, input logic [XLEN-1:0] i_pc,
                       input logic i_rfe, input logic i_wr, input logic [15:0] i_wd);
      int kind; // 0 idle 1 entry 2 fatal 3 return 4 write
      logic [CW-1:0]   e_cause;
      logic [15:0]     e_sr, e_esr, marked;
      logic [XLEN-1:0] e_epcr, e_rpc;
      string tsel;
      @(negedge clk);
      sv = i_sv; sc = i_sc; irq_ext = i_ext; irq_tick = i_tick; ds = i_ds;
      pc = i_pc; rfe = i_rfe; wr = i_wr; wd = i_wd;
      kind = 0; e_cause = '0; e_sr = m_sr; e_esr = m_esr; e_epcr = m_epcr; e_rpc = '0;
      tsel = "R6";
      if (i_sv) begin
         tsel = (i_ext || i_tick) ? "R8" : "R5";
         if (i_sc == 0 || int'(i_sc) >= NC) kind = 2;
         else begin kind = 1; e_cause = i_sc; end
      end else if (i_tick && m_sr[1]) begin
         kind = 1; e_cause = 4'd5; tsel = (i_ext && m_sr[2]) ? "R7" : "R6";
      end else if (i_ext && m_sr[2]) begin
         kind = 1; e_cause = 4'd8;
      end else if (i_rfe) kind = 3;
      else if (i_wr) kind = 4;
      case (kind)
         1: begin
            marked = i_ds ? (m_sr | 16'h2000) : m_sr;
            e_esr  = marked;
            e_sr   = (marked & ~16'h0066) | 16'h0001;
            e_epcr = i_pc - (i_ds ? 32'd4 : 32'd0) + ((i_sv && i_sc == 4'd12) ? 32'd4 : 32'd0);
            e_rpc  = {24'd0, 4'd0, e_cause} << 8;
         end
         3: begin e_sr = m_esr; e_rpc = m_epcr; end
         4: e_sr = i_wd;
         default: ;
      endcase
      @(posedge clk);
      #1;
      if (kind == 1) begin
         chk(tsel, "cause_o", 32'(cause), 32'(e_cause));
         chk("R5", "redirect_o", 32'(redirect), 32'd1);
         chk("R5", "redirect_pc_o", rpc, e_rpc);
         chk("R10", "tlb_flush_o", 32'(flush), 32'd1);
         chk("R4", "esr_o", 32'(esr), 32'(e_esr));
         chk(i_ds ? "R2" : "R4", "sr_o", 32'(sr), 32'(e_sr));
         chk((i_sv && i_sc == 4'd12) ? "R3" : "R2", "epcr_o", epcr, e_epcr);
         chk("R2", "dslot_clr_o", 32'(dclr), 32'(i_ds));
         chk("R9", "fatal_o", 32'(fatal), 32'd0);
      end else begin
         chk(kind == 2 ? "R9" : "R11", "cause_o", 32'(cause), 32'd0);
         chk(kind == 2 ? "R9" : "R10", "tlb_flush_o", 32'(flush), 32'd0);
         chk("R9", "fatal_o", 32'(fatal), 32'(kind == 2));
         chk(kind == 3 ? "R12" : "R6", "redirect_o", 32'(redirect), 32'(kind == 3));
         if (kind == 3) chk("R12", "redirect_pc_o", rpc, e_rpc);
         chk(kind == 4 ? "R13" : (kind == 3 ? "R12" : "R9"), "sr_o", 32'(sr), 32'(e_sr));
         chk(kind == 2 ? "R9" : "R6", "esr_o", 32'(esr), 32'(e_esr));
         chk(kind == 2 ? "R9" : "R6", "epcr_o", epcr, e_epcr);
         chk("R2", "dslot_clr_o", 32'(dclr), 32'd0);
      end
      m_sr = e_sr; m_esr = e_esr; m_epcr = e_epcr;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "sr_o", 32'(sr), 32'h0001);
      chk("R1", "esr_o", 32'(esr), 32'd0);
      chk("R1", "epcr_o", epcr, 32'd0);
      chk("R1", "pulses", {28'd0, redirect, flush, fatal, dclr}, 32'd0);
      chk("R1", "cause_o", 32'(cause), 32'd0);

      // directed corners
      step(0, 0, 1, 1, 0, 32'h0, 0, 0, 16'h0);          // R6: disabled requests
      step(0, 0, 0, 0, 0, 32'h0, 0, 1, 16'h00E6);       // R13: enable all
      step(0, 0, 1, 1, 0, 32'h400, 0, 0, 16'h0);        // R7: tick wins
      step(0, 0, 0, 0, 0, 32'h0, 1, 0, 16'h0);          // R12: return
      step(0, 0, 1, 0, 0, 32'h800, 0, 0, 16'h0);        // R6: external taken
      step(0, 0, 0, 0, 0, 32'h0, 1, 0, 16'h0);          // R12
      step(0, 0, 0, 0, 0, 32'h0, 0, 1, 16'h0002);       // tick only enabled
      step(0, 0, 1, 0, 0, 32'h0, 0, 0, 16'h0);          // R6: external masked
      step(1, 4'd12, 0, 0, 1, 32'h1000, 0, 0, 16'h0);   // R2 R3: syscall in slot
      step(1, 4'd12, 0, 0, 0, 32'h2000, 0, 0, 16'h0);   // R3
      step(1, 4'd3, 0, 0, 1, 32'h0, 0, 0, 16'h0);       // R2: wrap
      step(1, 4'd0, 1, 1, 0, 32'h10, 1, 1, 16'hFFFF);   // R9
      step(1, 4'd14, 0, 0, 0, 32'h10, 0, 0, 16'h0);     // R9
      step(1, 4'd15, 0, 0, 1, 32'h10, 0, 0, 16'h0);     // R9
      step(0, 0, 0, 0, 0, 32'h0, 0, 1, 16'hFFFF);       // R13
      step(1, 4'd13, 1, 1, 0, 32'h3000, 0, 0, 16'h0);   // R8: sync wins
      step(0, 0, 0, 0, 0, 32'h0, 0, 0, 16'h0);          // R11: idle after entry

      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic r_sv, r_rfe, r_wr;
         r_sv  = ($urandom % 4) == 0;
         r_rfe = ($urandom % 8) == 0;
         r_wr  = ($urandom % 6) == 0;
         step(r_sv, CW'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2),
              1'($urandom % 2), $urandom & 32'hFFFF_FFFC, r_rfe, r_wr, 16'($urandom));
      end
      step(0, 0, 0, 0, 0, 32'h0, 0, 0, 16'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule